// File: doc/BRIEF.md
# Power-Sequenced Serial Flash Bus Controller

This block drives an external serial flash device through a small command mailbox. A host presents a function code together with its operands; the controller latches the code into its function register, carries out the operation, and writes zero back to the register when it has finished. A zero function register therefore means the controller is ready, and any non-zero value means it is busy.

Besides plain data transfers, the controller owns the target's supply. It drives an active-low supply switch and holds the bus pins tristated until the supply has had time to rise. On power-down it releases every pin, and it stays busy until the supply has had time to decay. Chip select is only ever pulled low. To deselect, the controller releases the pin and an external pull-up takes it high. Reads take a bit count and a mask, so odd-length fields can be fetched without extra host work. Writes start at a caller-chosen most significant bit.

Top module: `spi_flash_seq`

## Requirements
- R1: Function code values: 0 ready, 1 init, 2 power-on, 3 power-off, 4 trigger, 5 select, 6 deselect, 7 protect, 8 unprotect, 9 read, 10 write, 11 set-frequency. After reset the function register reads 0, and the supply switch and every bus pin are tristated.
- R2: A command is accepted only while the function register is 0, and its code then appears in that register. Commands offered while it is non-zero are dropped, and so are codes 12 to 15. The register returns to 0 when the operation ends.
- R3: Init disables all bus pin drivers, sets the MOSI latch to 0, clears the select and protect latches, sets the HOLD# latch high and leaves SCLK at the idle level of the current mode. It does not change the supply switch.
- R4: Power-on acts only when the supply switch is off and the bus drivers are disabled. It drives the switch low, keeps the bus tristated for PWRUP_CYC cycles, then enables the bus drivers and stays busy for a further SETTLE_CYC cycles. If that condition does not hold, it returns to ready with no change.
- R5: Power-off releases the supply switch and every bus pin to high impedance in the same cycle, and the controller stays busy for PWRDN_CYC cycles.
- R6: Select drives CE# to 0. Deselect releases CE# to high impedance. CE# is never driven to 1.
- R7: Protect drives WP# to 0 and unprotect drives it to 1, while the bus is enabled.
- R8: Write shifts out the data word MSB first. It starts at the single set bit of the select operand and ends at bit 0, one SCLK pulse per bit. A zero select produces no pulse.
- R9: Read preloads its accumulator with the mask, shifts in the requested number of bits MSB first, and returns the accumulator ANDed with the mask. Bits above the length therefore keep mask bits unless the mask clears them. A length of 0 returns the mask at once.
- R10: SCLK idles at 0 when the mode input is 0 (mode 0) and at 1 when it is 1 (mode 3). Each bit is a low half then a high half. MISO is sampled at the rising edge and MOSI changes only at bit boundaries.
- R11: Set-frequency loads the SCLK half period in clock cycles from the low bits of the data operand, with 0 treated as 1. When the half period is below FAST_HALF, only SCLK output 0 is enabled; otherwise all N_SCLK outputs are enabled.
- R12: Trigger releases CE# and emits exactly 8 SCLK pulses, then returns to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_func | input | 4 | Function code |
| cmd_word | input | W | Write data, or half period for set-frequency |
| cmd_sel | input | W | Write MSB select, or read mask |
| cmd_len | input | LW | Read bit length |
| spi_mode3 | input | 1 | 0 selects mode 0, 1 selects mode 3 |
| func_state | output | 4 | Function register, 0 when ready |
| rd_data | output | W | Last read result |
| pwr_sw_n_o | output | 1 | Supply switch level (active low) |
| pwr_sw_n_oe | output | 1 | Supply switch driver enable |
| cs_n_o | output | 1 | CE# level |
| cs_n_oe | output | 1 | CE# driver enable |
| sclk_o | output | N_SCLK | Parallel SCLK levels |
| sclk_oe | output | N_SCLK | Parallel SCLK driver enables |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_i | input | 1 | Serial data in |
| wp_n_o | output | 1 | WP# level |
| wp_n_oe | output | 1 | WP# driver enable |
| hold_n_o | output | 1 | HOLD# level |
| hold_n_oe | output | 1 | HOLD# driver enable |

## Verification
Transfers are tried with random data words, random starting bit positions, random read lengths and masks, random MISO patterns, both clock modes and half periods from 1 to 4. Random masks wider than the length show whether the accumulator is preloaded. Mixed modes show the idle level each mode leaves behind. Directed cases cover the rest:
- a zero write select and a 4-bit read under an 8-bit mask, which separate the boundary handling;
- a select issued during the power-up wait, which shows whether busy commands are dropped;
- a repeated power-on, which shows the entry guard;
- probes inside the power-up and power-down windows, which separate the two timed phases.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;
  typedef enum logic [3:0] {
    FN_READY    = 4'd0,
    FN_INIT     = 4'd1,
    FN_PWR_ON   = 4'd2,
    FN_PWR_OFF  = 4'd3,
    FN_TRIGGER  = 4'd4,
    FN_CE_LO    = 4'd5,
    FN_CE_HI    = 4'd6,
    FN_WP_LO    = 4'd7,
    FN_WP_HI    = 4'd8,
    FN_READ     = 4'd9,
    FN_WRITE    = 4'd10,
    FN_SET_FREQ = 4'd11
  } fn_e;

  localparam logic [3:0] FN_LAST = 4'd11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PU_WAIT, ST_SETTLE, ST_PD_WAIT, ST_XFER, ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    XK_PULSE, XK_READ, XK_WRITE
  } xk_e;

  localparam int TRIG_PULSES = 8;
endpackage

// File: rtl/sfseq_timer.sv
module sfseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sfseq_bitclk.sv
module sfseq_bitclk #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half,
  output logic            hi_phase,
  output logic            rise_evt,
  output logic            bit_end
);
  logic [DIVW-1:0] hc_q, hc_d;
  logic            ph_q, ph_d;
  logic            wrap;

  assign wrap = (hc_q == half - 1'b1);

  always_comb begin
    hc_d = hc_q;
    ph_d = ph_q;
    if (!run) begin
      hc_d = '0;
      ph_d = 1'b0;
    end else if (wrap) begin
      hc_d = '0;
      ph_d = ~ph_q;
    end else begin
      hc_d = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      ph_q <= 1'b0;
    end else begin
      hc_q <= hc_d;
      ph_q <= ph_d;
    end
  end

  assign hi_phase = ph_q;
  assign rise_evt = run && !ph_q && wrap;
  assign bit_end  = run &&  ph_q && wrap;

  // Every bit opens with its low half (R10).
  assert_bit_starts_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hi_phase);
endmodule

// File: rtl/sfseq_shift.sv
module sfseq_shift
  import sfseq_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  input  xk_e           kind,
  input  logic [W-1:0]  data,
  input  logic [W-1:0]  sel,
  input  logic [LW-1:0] len,
  input  logic          rise_evt,
  input  logic          bit_end,
  input  logic          miso,
  output logic          mosi,
  output logic          last,
  output logic [W-1:0]  result
);
  xk_e           kind_q, kind_d;
  logic [W-1:0]  tx_q, tx_d, sel_q, sel_d, acc_q, acc_d, mask_q, mask_d;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    kind_d = kind_q;
    tx_d   = tx_q;
    sel_d  = sel_q;
    acc_d  = acc_q;
    mask_d = mask_q;
    cnt_d  = cnt_q;
    if (clear) begin
      tx_d  = '0;
      sel_d = '0;
    end else if (start) begin
      kind_d = kind;
      case (kind)
        XK_WRITE: begin
          tx_d  = data;
          sel_d = sel;
        end
        XK_READ: begin
          acc_d  = sel;
          mask_d = sel;
          cnt_d  = len;
        end
        default: cnt_d = LW'(TRIG_PULSES);
      endcase
    end else begin
      if (rise_evt && kind_q == XK_READ) acc_d = {acc_q[W-2:0], miso};
      if (bit_end) begin
        if (kind_q == XK_WRITE)  sel_d = sel_q >> 1;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= XK_PULSE;
      tx_q   <= '0;
      sel_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      kind_q <= kind_d;
      tx_q   <= tx_d;
      sel_q  <= sel_d;
      acc_q  <= acc_d;
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mosi   = |(tx_q & sel_q);
  assign last   = (kind_q == XK_WRITE) ? (sel_q[W-1:1] == '0) : (cnt_q <= LW'(1));
  assign result = acc_q & mask_q;
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import sfseq_pkg::*;
#(
  parameter  int W          = 32,
  parameter  int DIVW       = 8,
  parameter  int N_SCLK     = 4,
  parameter  int FAST_HALF  = 2,
  parameter  int DEF_HALF   = 4,
  parameter  int PWRUP_CYC  = 1000000,
  parameter  int SETTLE_CYC = 100000,
  parameter  int PWRDN_CYC  = 5000000,
  localparam int LW         = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_func,
  input  logic [W-1:0]      cmd_word,
  input  logic [W-1:0]      cmd_sel,
  input  logic [LW-1:0]     cmd_len,
  input  logic              spi_mode3,
  output logic [3:0]        func_state,
  output logic [W-1:0]      rd_data,
  output logic              pwr_sw_n_o,
  output logic              pwr_sw_n_oe,
  output logic              cs_n_o,
  output logic              cs_n_oe,
  output logic [N_SCLK-1:0] sclk_o,
  output logic [N_SCLK-1:0] sclk_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              wp_n_o,
  output logic              wp_n_oe,
  output logic              hold_n_o,
  output logic              hold_n_oe
);
  localparam int MAX_AB = (PWRUP_CYC > SETTLE_CYC) ? PWRUP_CYC : SETTLE_CYC;
  localparam int MAX_C  = (MAX_AB > PWRDN_CYC) ? MAX_AB : PWRDN_CYC;
  localparam int TW     = $clog2(MAX_C + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  logic [3:0]      func_q, func_d;
  st_e             st_q, st_d;
  logic            sup_on_q, sup_on_d, bus_en_q, bus_en_d;
  logic            cs_act_q, cs_act_d, wp_low_q, wp_low_d, hold_hi_q, hold_hi_d;
  logic [DIVW-1:0] half_q, half_d;
  logic [W-1:0]    rd_q, rd_d;

  logic            tmr_load, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            sh_start, sh_clear, sh_mosi, sh_last;
  xk_e             sh_kind;
  logic [W-1:0]    sh_result;
  logic            run, hi_phase, rise_evt, bit_end, fast;

  assign run = (st_q == ST_XFER);

  sfseq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_s), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sfseq_bitclk #(.DIVW(DIVW)) u_bitclk (
    .clk(clk), .rst_n(rst_s), .run(run), .half(half_q),
    .hi_phase(hi_phase), .rise_evt(rise_evt), .bit_end(bit_end)
  );

  sfseq_shift #(.W(W), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_s), .clear(sh_clear), .start(sh_start), .kind(sh_kind),
    .data(cmd_word), .sel(cmd_sel), .len(cmd_len),
    .rise_evt(rise_evt), .bit_end(bit_end), .miso(miso_i),
    .mosi(sh_mosi), .last(sh_last), .result(sh_result)
  );

  always_comb begin
    func_d    = func_q;
    st_d      = st_q;
    sup_on_d  = sup_on_q;
    bus_en_d  = bus_en_q;
    cs_act_d  = cs_act_q;
    wp_low_d  = wp_low_q;
    hold_hi_d = hold_hi_q;
    half_d    = half_q;
    rd_d      = rd_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    sh_start  = 1'b0;
    sh_clear  = 1'b0;
    sh_kind   = XK_PULSE;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid && cmd_func != 4'd0 && cmd_func <= FN_LAST) begin
          func_d = cmd_func;
          st_d   = ST_DONE;
          case (fn_e'(cmd_func))
            FN_INIT: begin
              bus_en_d  = 1'b0;
              cs_act_d  = 1'b0;
              wp_low_d  = 1'b0;
              hold_hi_d = 1'b1;
              sh_clear  = 1'b1;
            end
            FN_PWR_ON: begin
              if (!bus_en_q && !sup_on_q) begin
                sup_on_d = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(PWRUP_CYC);
                st_d     = ST_PU_WAIT;
              end
            end
            FN_PWR_OFF: begin
              sup_on_d = 1'b0;
              bus_en_d = 1'b0;
              cs_act_d = 1'b0;
              tmr_load = 1'b1;
              tmr_val  = TW'(PWRDN_CYC);
              st_d     = ST_PD_WAIT;
            end
            FN_TRIGGER: begin
              cs_act_d = 1'b0;
              sh_start = 1'b1;
              sh_kind  = XK_PULSE;
              st_d     = ST_XFER;
            end
            FN_CE_LO: cs_act_d = 1'b1;
            FN_CE_HI: cs_act_d = 1'b0;
            FN_WP_LO: wp_low_d = 1'b1;
            FN_WP_HI: wp_low_d = 1'b0;
            FN_READ: begin
              if (cmd_len == '0) begin
                rd_d = cmd_sel;
              end else begin
                sh_start = 1'b1;
                sh_kind  = XK_READ;
                st_d     = ST_XFER;
              end
            end
            FN_WRITE: begin
              if (cmd_sel != '0) begin
                sh_start = 1'b1;
                sh_kind  = XK_WRITE;
                st_d     = ST_XFER;
              end
            end
            FN_SET_FREQ: begin
              half_d = (cmd_word[DIVW-1:0] == '0) ? DIVW'(1) : cmd_word[DIVW-1:0];
            end
            default: ;
          endcase
        end
      end
      ST_PU_WAIT: begin
        if (tmr_zero) begin
          bus_en_d = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC);
          st_d     = ST_SETTLE;
        end
      end
      ST_SETTLE:  if (tmr_zero) st_d = ST_DONE;
      ST_PD_WAIT: if (tmr_zero) st_d = ST_DONE;
      ST_XFER: begin
        if (bit_end && sh_last) begin
          st_d = ST_DONE;
          if (func_q == FN_READ) rd_d = sh_result;
        end
      end
      ST_DONE: begin
        func_d = 4'd0;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      func_q    <= 4'd0;
      st_q      <= ST_IDLE;
      sup_on_q  <= 1'b0;
      bus_en_q  <= 1'b0;
      cs_act_q  <= 1'b0;
      wp_low_q  <= 1'b0;
      hold_hi_q <= 1'b0;
      half_q    <= DIVW'(DEF_HALF);
      rd_q      <= '0;
    end else begin
      func_q    <= func_d;
      st_q      <= st_d;
      sup_on_q  <= sup_on_d;
      bus_en_q  <= bus_en_d;
      cs_act_q  <= cs_act_d;
      wp_low_q  <= wp_low_d;
      hold_hi_q <= hold_hi_d;
      half_q    <= half_d;
      rd_q      <= rd_d;
    end
  end

  // pin drive
  assign fast        = (half_q < DIVW'(FAST_HALF));
  assign func_state  = func_q;
  assign rd_data     = rd_q;
  assign pwr_sw_n_o  = 1'b0;
  assign pwr_sw_n_oe = sup_on_q;
  assign cs_n_o      = 1'b0;
  assign cs_n_oe     = bus_en_q & cs_act_q;
  assign mosi_o      = sh_mosi;
  assign mosi_oe     = bus_en_q;
  assign wp_n_o      = ~wp_low_q;
  assign wp_n_oe     = bus_en_q;
  assign hold_n_o    = hold_hi_q;
  assign hold_n_oe   = bus_en_q;

  for (genvar g = 0; g < N_SCLK; g++) begin : g_sclk
    assign sclk_o[g]  = run ? hi_phase : spi_mode3;
    assign sclk_oe[g] = bus_en_q & ((g == 0) | ~fast);
  end

  // Bus drivers only run on a powered target (R4).
  assert_bus_needs_supply_R4: assert property (@(posedge clk) disable iff (!rst_s)
    mosi_oe |-> pwr_sw_n_oe);

  // CE# is pulled low or released, never driven high (R6).
  assert_cs_never_high_R6: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n_oe |-> !cs_n_o);

  // A busy function register holds its code (R2).
  assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (func_q != 4'd0 && st_q != ST_DONE) |=> func_q == $past(func_q));

  // At high rates at most one SCLK driver is enabled (R11).
  assert_fast_single_sclk_R11: assert property (@(posedge clk) disable iff (!rst_s)
    fast |-> $countones(sclk_oe) <= 1);

  // The trigger burst runs with CE# released (R12).
  assert_trigger_cs_free_R12: assert property (@(posedge clk) disable iff (!rst_s)
    (func_q == FN_TRIGGER && run) |-> !cs_n_oe);

  // Power-off takes the supply switch off in the cycle after it is accepted (R5).
  assert_pwroff_releases_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_PD_WAIT) |-> !pwr_sw_n_oe && !mosi_oe);
endmodule

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;
  localparam int W = 32;
  localparam int LW = 6;
  localparam int NS = 4;
  localparam int PU = 300;
  localparam int ST = 40;
  localparam int PD = 500;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [3:0] cmd_func;
  logic [W-1:0] cmd_word, cmd_sel;
  logic [LW-1:0] cmd_len;
  logic spi_mode3;
  logic [3:0] func_state;
  logic [W-1:0] rd_data;
  logic pwr_sw_n_o, pwr_sw_n_oe, cs_n_o, cs_n_oe, mosi_o, mosi_oe, miso_i;
  logic wp_n_o, wp_n_oe, hold_n_o, hold_n_oe;
  logic [NS-1:0] sclk_o, sclk_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_flash_seq #(.W(W), .N_SCLK(NS), .FAST_HALF(2), .DEF_HALF(4),
                  .PWRUP_CYC(PU), .SETTLE_CYC(ST), .PWRDN_CYC(PD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_word(cmd_word), .cmd_sel(cmd_sel), .cmd_len(cmd_len), .spi_mode3(spi_mode3),
    .func_state(func_state), .rd_data(rd_data),
    .pwr_sw_n_o(pwr_sw_n_o), .pwr_sw_n_oe(pwr_sw_n_oe),
    .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .wp_n_o(wp_n_o), .wp_n_oe(wp_n_oe), .hold_n_o(hold_n_o), .hold_n_oe(hold_n_oe)
  );

  // target model: counts SCLK rises, captures MOSI, serves MISO
  int rises = 0;
  int cs_rises = 0;
  logic [W-1:0] cap = '0;
  logic [W-1:0] pat = '0;
  int rd_len = 0;
  int rd_base = 0;
  int midx;

  always @(posedge sclk_o[0]) begin
    cap = {cap[W-2:0], mosi_o};
    if (cs_n_oe) cs_rises = cs_rises + 1;
    rises = rises + 1;
  end

  assign midx   = rd_len - 1 - (rises - rd_base);
  assign miso_i = (midx >= 0 && midx < W) ? pat[midx] : 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] f, input logic [W-1:0] wd,
                      input logic [W-1:0] sl, input logic [LW-1:0] ln);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_word = wd; cmd_sel = sl; cmd_len = ln;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (func_state != 4'd0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [W-1:0] exp_rd(input logic [W-1:0] m, input int n,
                                          input logic [W-1:0] p);
    logic [W-1:0] a = m;
    for (int i = n - 1; i >= 0; i--) a = {a[W-2:0], p[i]};
    return a & m;
  endfunction

  task automatic set_mode_half(input bit md, input int h);
    int c;
    @(negedge clk);
    spi_mode3 = md;
    send(4'd11, W'(h), '0, '0);
    wait_ready(c);
    check(sclk_oe == ((h < 2) ? 4'b0001 : 4'b1111), "R11 sclk enables", sclk_oe,
          (h < 2) ? 4'b0001 : 4'b1111);
  endtask

  task automatic run_write(input bit md, input int h, input logic [W-1:0] d, input int p);
    int c, b, n;
    logic [63:0] m;
    set_mode_half(md, h);
    b = rises;
    send(4'd10, d, W'(64'd1 << p), '0);
    wait_ready(c);
    n = rises - b;
    m = (64'd1 << (p + 1)) - 1;
    check(n == p + 1, "R8 write pulse count", n, p + 1);
    check((64'(cap) & m) == (64'(d) & m), "R8 write bits", 64'(cap) & m, 64'(d) & m);
    check(sclk_o[0] == md, "R10 idle level after write", sclk_o[0], md);
    check(c >= 2 * h * (p + 1) - 2 && c <= 2 * h * (p + 1) + 3, "R11 write duration",
          c, 2 * h * (p + 1));
  endtask

  task automatic run_read(input bit md, input int h, input logic [W-1:0] m, input int n,
                          input logic [W-1:0] p);
    int c, b;
    set_mode_half(md, h);
    @(negedge clk);
    pat = p; rd_len = n; rd_base = rises; b = rises;
    send(4'd9, '0, m, LW'(n));
    wait_ready(c);
    check(rd_data == exp_rd(m, n, p), "R9 read result", rd_data, exp_rd(m, n, p));
    check(rises - b == n, "R10 read pulse count", rises - b, n);
    check(sclk_o[0] == md, "R10 idle level after read", sclk_o[0], md);
    @(negedge clk);
    rd_len = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int c, b;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_func = '0; cmd_word = '0; cmd_sel = '0;
    cmd_len = '0; spi_mode3 = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(func_state == 0, "R1 reset ready", func_state, 0);
    check({pwr_sw_n_oe, cs_n_oe, mosi_oe, wp_n_oe, hold_n_oe, sclk_oe} == '0,
          "R1 all tristated", {pwr_sw_n_oe, mosi_oe, sclk_oe}, 0);

    // R2 out-of-range code dropped
    send(4'd13, '0, '0, '0);
    check(func_state == 0, "R2 bad code ignored", func_state, 0);

    // R3 init
    send(4'd1, '0, '0, '0);
    check(func_state == 4'd1, "R2 code visible while busy", func_state, 1);
    wait_ready(c);
    check(hold_n_o == 1 && mosi_o == 0 && sclk_o[0] == 0 && wp_n_o == 1 && mosi_oe == 0,
          "R3 init latches", {hold_n_o, mosi_o, sclk_o[0], wp_n_o, mosi_oe}, 5'b10010);

    // R4 power-on sequence, with R2 drop of a command while busy
    send(4'd2, '0, '0, '0);
    repeat (20) @(negedge clk);
    check(pwr_sw_n_oe == 1 && pwr_sw_n_o == 0, "R4 switch on", pwr_sw_n_oe, 1);
    check(mosi_oe == 0 && sclk_oe == 0, "R4 bus still off", mosi_oe, 0);
    send(4'd5, '0, '0, '0);
    repeat (PU - 10) @(negedge clk);
    check(mosi_oe == 1 && func_state == 4'd2, "R4 bus on during settle",
          {mosi_oe, func_state}, 5'h12);
    wait_ready(c);
    check(c + PU + 12 >= PU + ST, "R4 total wait", c + PU + 12, PU + ST);
    check(cs_n_oe == 0, "R2 busy command dropped", cs_n_oe, 0);
    send(4'd2, '0, '0, '0);
    wait_ready(c);
    check(c <= 2 && pwr_sw_n_oe == 1, "R4 repeated power-on no-op", c, 1);

    // R6 chip select
    send(4'd5, '0, '0, '0); wait_ready(c);
    check(cs_n_oe == 1 && cs_n_o == 0, "R6 select drives low", {cs_n_oe, cs_n_o}, 2'b10);
    send(4'd6, '0, '0, '0); wait_ready(c);
    check(cs_n_oe == 0, "R6 deselect releases", cs_n_oe, 0);

    // R7 write protect
    send(4'd7, '0, '0, '0); wait_ready(c);
    check(wp_n_oe == 1 && wp_n_o == 0, "R7 protect", wp_n_o, 0);
    send(4'd8, '0, '0, '0); wait_ready(c);
    check(wp_n_o == 1, "R7 unprotect", wp_n_o, 1);

    // R12 trigger with select active beforehand
    set_mode_half(1'b0, 1);
    send(4'd5, '0, '0, '0); wait_ready(c);
    b = rises;
    begin
      int cb = cs_rises;
      send(4'd4, '0, '0, '0); wait_ready(c);
      check(rises - b == 8, "R12 trigger pulses", rises - b, 8);
      check(cs_rises == cb && cs_n_oe == 0, "R12 select released", cs_rises - cb, 0);
    end

    // R8 zero select, R9 short read under wide mask
    b = rises;
    send(4'd10, 32'hFFFF_FFFF, '0, '0); wait_ready(c);
    check(rises == b && c <= 2, "R8 zero select no pulse", rises - b, 0);
    run_read(1'b0, 2, 32'h0000_00FF, 4, 32'h0000_0005);
    run_read(1'b1, 1, 32'h0000_0F0F, 0, 32'h0);
    run_write(1'b1, 3, 32'hA5C3_0F96, 31);
    run_write(1'b0, 1, 32'h0000_0001, 0);

    // random mix
    for (int i = 0; i < 25; i++) begin
      run_write(1'($urandom), 1 + int'($urandom % 4), $urandom, int'($urandom % 32));
      run_read(1'($urandom), 1 + int'($urandom % 4), $urandom, 1 + int'($urandom % 32),
               $urandom);
    end

    // R5 power-off
    send(4'd3, '0, '0, '0);
    check(pwr_sw_n_oe == 0 && mosi_oe == 0 && sclk_oe == 0 && wp_n_oe == 0,
          "R5 all released", {pwr_sw_n_oe, mosi_oe}, 0);
    repeat (PD - 10) @(negedge clk);
    check(func_state == 4'd3, "R5 still busy", func_state, 3);
    wait_ready(c);
    check(c <= 20 && func_state == 0, "R5 ready after decay", c, 12);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule